// File: doc/BRIEF.md
# Sequential Signed Integer Divider

This block performs 32-bit signed integer division for a processor ALU, one quotient bit per clock, instead of a single-cycle combinational divider. A single start pulse delivers dividend, divisor and an operation select that chooses between quotient and remainder. The block takes the magnitudes of both operands and runs a restoring shift-and-subtract loop for as many cycles as the operand has bits. It then fixes the sign of the result and raises a one-cycle done pulse.

The requesting core waits in a dedicated stall state while busy is high and resumes on done. Quotients truncate toward zero and remainders carry the sign of the dividend, which matches common high-level language integer semantics. A zero divisor skips the loop. It returns done on the very next cycle with a divide-by-zero flag so the core can take a trap. Dividing the most-negative value by -1 wraps to the most-negative value, with a zero remainder.

Top module: `sdiv_seq`

## Requirements
- R1: After reset, busy, done and div_by_zero are 0 and result is 0.
- R2: A start pulse seen while busy is 0 and with a nonzero divisor is accepted at that clock edge. From the next cycle, busy stays 1 until the cycle in which done is 1.
- R3: For a nonzero divisor, done is 1 for exactly one cycle, W+1 clock edges after the accepting edge (33 for W=32). busy is 0 in that cycle.
- R4: With want_rem = 0, result is the quotient, truncated toward zero (for example -100/7 = -14 and 100/-7 = -14).
- R5: With want_rem = 1, result is the remainder, which is zero or carries the sign of the dividend (for example -100 rem 7 = -2 and 100 rem -7 = 2).
- R6: A start with divisor 0 gives done = 1, div_by_zero = 1 and result = 0 in the next cycle. busy never rises.
- R7: The most-negative dividend divided by -1 yields quotient 0x80000000 and remainder 0, and completes in the normal latency.
- R8: A start pulse while busy is 1 is ignored. The operation in flight completes with its own result, and no extra done follows.
- R9: result and div_by_zero hold their values from a completion until the next accepted start. div_by_zero is 0 after any completion with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, honoured only while idle |
| dividend | input | W | Signed dividend |
| divisor | input | W | Signed divisor |
| want_rem | input | 1 | 0 selects quotient, 1 selects remainder |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle completion pulse |
| div_by_zero | output | 1 | Set with done when the divisor was zero |
| result | output | W | Signed quotient or remainder |

## Verification
The bench targets mixed-sign operands in both modes. A design that corrected signs the wrong way would round toward minus infinity or give the remainder the divisor's sign. It also issues the most-negative dividend divided by -1 and by 1. Here a design with an unsigned magnitude slip or an overflow trap would return a wrong value or never finish. Zero divisors and start pulses issued during a busy period are also applied. These catch a design that iterates on a zero divisor, reports done late, or lets a stray request corrupt the running division. Each completion is also checked against its exact expected cycle.

// File: rtl/sdiv_seq.sv
module sdiv_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         want_rem,
  output logic         busy,
  output logic         done,
  output logic         div_by_zero,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dvs_q;
  logic          negq_q, negr_q, sel_q;

  wire          a_neg   = dividend[W-1];
  wire          b_neg   = divisor[W-1];
  wire [W-1:0]  a_mag   = a_neg ? -dividend : dividend;
  wire [W-1:0]  b_mag   = b_neg ? -divisor : divisor;
  wire [W:0]    shifted = {rem_q[W-1:0], quo_q[W-1]};
  wire [W:0]    trial   = shifted - {1'b0, dvs_q};
  wire [W-1:0]  q_fix   = negq_q ? -quo_q : quo_q;
  wire [W-1:0]  r_fix   = negr_q ? -rem_q[W-1:0] : rem_q[W-1:0];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      rem_q       <= '0;
      quo_q       <= '0;
      dvs_q       <= '0;
      negq_q      <= 1'b0;
      negr_q      <= 1'b0;
      sel_q       <= 1'b0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
      result      <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (divisor == '0) begin
              done        <= 1'b1;
              div_by_zero <= 1'b1;
              result      <= '0;
            end else begin
              div_by_zero <= 1'b0;
              st          <= S_RUN;
              cnt         <= '0;
              rem_q       <= '0;
              quo_q       <= a_mag;
              dvs_q       <= b_mag;
              negq_q      <= a_neg ^ b_neg;
              negr_q      <= a_neg;
              sel_q       <= want_rem;
            end
          end
        end
        S_RUN: begin
          if (!trial[W]) begin
            rem_q <= trial;
            quo_q <= {quo_q[W-2:0], 1'b1};
          end else begin
            rem_q <= shifted;
            quo_q <= {quo_q[W-2:0], 1'b0};
          end
          cnt <= cnt + CW'(1);
          if (cnt == CW'(W - 1)) st <= S_FIN;
        end
        S_FIN: begin
          result <= sel_q ? r_fix : q_fix;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_seq_chk.sv
module sdiv_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         div_by_zero
);
  localparam int KW = $clog2(W + 4) + 1;
  logic [KW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (start && !busy && divisor != '0) since <= KW'(1);
    else if (done) since <= '0;
    else if (since != '0) since <= since + KW'(1);
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && divisor != '0 |=> busy && !done);
  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && divisor == '0 |=> done && div_by_zero && !busy);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !div_by_zero |-> since == KW'(W + 2));
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(div_by_zero));
endmodule

bind sdiv_seq sdiv_seq_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
  .busy(busy), .done(done), .div_by_zero(div_by_zero)
);

// File: tb/sdiv_seq_tb_top.sv
module sdiv_seq_tb_top;
  localparam int W = 32;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         start = 0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic         want_rem = 0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] result;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct {
    logic [W-1:0] res;
    logic         dbz;
    int           due;
    string        req;
  } exp_t;
  exp_t sb[$];
  exp_t last;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdiv_seq #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .want_rem(want_rem), .busy(busy), .done(done),
    .div_by_zero(div_by_zero), .result(result)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(0, "R8 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result === e.res, e.req, result, e.res);
        chk(div_by_zero === e.dbz, {e.req, " flag"}, div_by_zero, e.dbz);
        chk(cyc == e.due, "R3 completion cycle", cyc, e.due);
        last = e;
      end
    end
  end

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic rem, input string req, input bit blocking);
    exp_t e;
    longint la, lb;
    @(negedge clk);
    while (busy) @(negedge clk);
    dividend = a; divisor = b; want_rem = rem; start = 1;
    la = longint'($signed(a)); lb = longint'($signed(b));
    if (b == '0) e.res = '0;
    else e.res = rem ? W'(la % lb) : W'(la / lb);
    e.dbz = (b == '0);
    e.due = cyc + ((b == '0) ? 1 : W + 2);
    e.req = req;
    sb.push_back(e);
    @(negedge clk);
    start = 0;
    chk(busy === (b != '0), "R2/R6 busy after start", busy, b != '0);
    if (blocking) while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] lf;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 0 && done === 0 && div_by_zero === 0, "R1 reset flags",
        {busy, done, div_by_zero}, 0);
    chk(result === '0, "R1 reset result", result, 0);
    rst_n = 1;
    @(negedge clk);

    issue(32'd100, 32'd7, 0, "R4 pos/pos quotient", 1);
    issue(-32'sd100, 32'd7, 0, "R4 neg/pos quotient", 1);
    issue(32'd100, -32'sd7, 0, "R4 pos/neg quotient", 1);
    issue(-32'sd100, -32'sd7, 0, "R4 neg/neg quotient", 1);
    issue(32'd7, 32'd100, 0, "R4 small dividend", 1);
    issue(32'd100, -32'sd7, 1, "R5 pos/neg remainder", 1);
    issue(-32'sd100, 32'd7, 1, "R5 neg/pos remainder", 1);
    issue(-32'sd100, -32'sd7, 1, "R5 neg/neg remainder", 1);
    issue(32'd0, 32'd5, 1, "R5 zero dividend", 1);
    issue(32'd1234, 32'd0, 0, "R6 zero divisor", 1);
    issue(32'h8000_0000, 32'd0, 1, "R6 zero divisor rem", 1);
    issue(32'h8000_0000, 32'hFFFF_FFFF, 0, "R7 min/-1 quotient", 1);
    issue(32'h8000_0000, 32'hFFFF_FFFF, 1, "R7 min/-1 remainder", 1);
    issue(32'h8000_0000, 32'd1, 0, "R7 min/1 quotient", 1);
    issue(32'h7FFF_FFFF, 32'h8000_0000, 1, "R5 max rem min", 1);

    // R8: a start during busy is ignored
    issue(32'd1000, 32'd3, 0, "R8 in-flight quotient", 0);
    repeat (5) @(negedge clk);
    dividend = 32'd5; divisor = 32'd0; want_rem = 1; start = 1;
    @(negedge clk);
    start = 0;
    while (sb.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    // R9 hold after completion
    chk(result === 32'd333, "R9 result hold", result, 333);
    chk(div_by_zero === 0, "R9 flag clear", div_by_zero, 0);

    lf = 32'hACE1_2345;
    for (int i = 0; i < 30; i++) begin
      logic [W-1:0] a, b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b = (i % 3 == 0) ? (lf >>> 20) : lf;
      if (i % 2 == 0) b = -b;
      issue(a, b, i[0], i[0] ? "R5 mixed remainder" : "R4 mixed quotient", 1);
    end

    repeat (4) @(negedge clk);
    chk(result === last.res, "R9 final hold", result, last.res);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule